// File: doc/BRIEF.md
# Broadcast Trigger Pulse Interface

This block pairs a transmitter and a receiver for one shared trigger line. The line is broadcast: the source never waits for an answer from the listeners. On the transmit side, a single-cycle or held fire request produces one active-high pulse. The pulse meets a minimum high time. After it, the line stays low for a minimum idle gap before another pulse may start. A request that arrives while a pulse or its gap is running is not lost. It is held and issued as soon as the gap ends. Any further requests that arrive while one is already held are merged into it.

On the receive side, the incoming line is first passed through a two-flop synchronizer. A one-cycle action strobe is then raised on the edge that the edge-select input picks: rising or falling. The timing limits are given in nanoseconds together with the clock period. They are converted to whole clock cycles by rounding up. With the default 10 ns clock, the pulse is 3 cycles high and the gap is 5 cycles low.

Top module: `bcast_trig_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `line_out`, `busy` and `act_strobe` are all 0.
- R2: When `fire_req` is 1 at a clock edge with the transmitter idle, `line_out` is 1 starting in the next cycle and stays 1 for exactly HIGH cycles (3 by default).
- R3: Between the end of one pulse and the start of the next, `line_out` stays 0 for at least GAP cycles (5 by default).
- R4: A request sampled while a pulse or its gap is in progress is held. Its pulse starts in the cycle right after the last gap cycle, which leaves exactly GAP low cycles between the two pulses.
- R5: Any number of requests sampled while a request is already held, or in the edge where a held request launches, together produce only one pulse.
- R6: `busy` is 1 from the cycle after a pulse is accepted through the last gap cycle (HIGH+GAP cycles when no request is held), and 0 otherwise. `line_out` is never 1 while `busy` is 0.
- R7: A change on `line_in` sampled at clock edge n appears as `act_strobe` in the cycle after edge n+1. This is the latency of the two synchronizer flops.
- R8: With `edge_sel` = 0, `act_strobe` pulses for each rising edge of the synchronized line and never for a falling edge.
- R9: With `edge_sel` = 1, `act_strobe` pulses for each falling edge of the synchronized line and never for a rising edge.
- R10: Each detected edge gives exactly one strobe cycle, however long the line then holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_req | input | 1 | Request to send one trigger pulse |
| line_out | output | 1 | Driven trigger line, active high |
| busy | output | 1 | Pulse or idle gap in progress |
| line_in | input | 1 | Received trigger line, asynchronous |
| edge_sel | input | 1 | Edge that triggers action: 0 rising, 1 falling |
| act_strobe | output | 1 | One-cycle action strobe |

## Verification
The embedded assertions check the following on every cycle:
- every pulse has exactly the high width;
- every low stretch between pulses reaches the gap;
- a held request launches straight after the gap;
- `busy` drops only once a full gap has passed;
- the line never rises while idle is reported;
- strobes never repeat on consecutive cycles and always agree with the synchronized level for the selected edge.

The bench's scenarios show what the assertions cannot. It sweeps a burst of one to three requests across every offset inside and beyond a first pulse. That sweep shows the merging of extra requests and the exact cycle of each launched pulse. A sweep of every 5-bit line pattern, run under both edge selections, shows the receiver's exact latency and that no edge is missed.

// File: rtl/bcast_trig_pkg.sv
package bcast_trig_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_HIGH = 2'd1,
    TX_GAP  = 2'd2
  } tx_state_e;

  // Whole cycles covering a time limit, rounded up, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Counter width able to hold the larger of two cycle counts.
  function automatic int unsigned cnt_width(input int unsigned a,
                                            input int unsigned b);
    int unsigned m;
    int unsigned w;
    m = (a > b) ? a : b;
    w = $clog2(m + 1);
    if (w == 0) w = 1;
    return w;
  endfunction

  // Edge detection for the selected polarity.
  function automatic logic edge_hit(input logic prev, input logic cur,
                                    input logic fall_mode);
    return fall_mode ? (prev & ~cur) : (~prev & cur);
  endfunction

endpackage

// File: rtl/bcast_pulse_tx.sv
module bcast_pulse_tx
  import bcast_trig_pkg::*;
#(
  parameter int unsigned HIGH_CYC = 3,
  parameter int unsigned GAP_CYC  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_req,
  output logic line_out,
  output logic busy
);

  localparam int unsigned CW = cnt_width(HIGH_CYC, GAP_CYC);
  localparam logic [CW-1:0] HIGH_LOAD = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] GAP_LOAD  = CW'(GAP_CYC - 1);

  tx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;

  // Named internal events
  logic high_done, gap_done, launch_now, absorb_req;

  assign high_done  = (state_q == TX_HIGH) && (cnt_q == '0);
  assign gap_done   = (state_q == TX_GAP) && (cnt_q == '0);
  assign launch_now = ((state_q == TX_IDLE) && fire_req) ||
                      (gap_done && (pend_q || fire_req));
  assign absorb_req = fire_req && (state_q != TX_IDLE) && !gap_done;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    if (launch_now) begin
      state_d = TX_HIGH;
      cnt_d   = HIGH_LOAD;
      pend_d  = 1'b0;
    end else if (high_done) begin
      state_d = TX_GAP;
      cnt_d   = GAP_LOAD;
    end else if (gap_done) begin
      state_d = TX_IDLE;
      cnt_d   = '0;
    end else if (state_q != TX_IDLE) begin
      cnt_d   = cnt_q - 1'b1;
    end
    if (absorb_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign line_out = (state_q == TX_HIGH);
  assign busy     = (state_q != TX_IDLE);

  // Observation counters for the assertions
  logic [CW:0] hi_run, lo_run;
  logic        line_q, seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      line_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      line_q <= line_out;
      if (line_out) begin
        seen_q <= 1'b1;
        lo_run <= '0;
        if (hi_run != '1) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run != '1) lo_run <= lo_run + 1'b1;
      end
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && !line_out) |-> (hi_run == (CW+1)'(HIGH_CYC)));

  // R3
  gap_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_q && line_out && seen_q) |-> (lo_run >= (CW+1)'(GAP_CYC)));

  // R4
  held_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_done && pend_q) |=> line_out);

  // R6
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_out |-> busy);

  // R6
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (lo_run == (CW+1)'(GAP_CYC)));

endmodule

// File: rtl/bcast_line_sync.sv
module bcast_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sr[0] <= 1'b0;
        else        sr[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sr[i] <= 1'b0;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/bcast_edge_rx.sv
module bcast_edge_rx
  import bcast_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic fall_mode,
  output logic strobe
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign strobe = edge_hit(prev_q, level, fall_mode);

  // R8
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !fall_mode) |-> level);

  // R9
  fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && fall_mode) |-> !level);

  // R10
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

endmodule

// File: rtl/bcast_trig_top.sv
module bcast_trig_top
  import bcast_trig_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned MIN_HIGH_NS   = 30,
  parameter int unsigned MIN_GAP_NS    = 50,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_req,
  output logic line_out,
  output logic busy,
  input  logic line_in,
  input  logic edge_sel,
  output logic act_strobe
);

  localparam int unsigned HIGH_CYC = ns_to_cycles(MIN_HIGH_NS, CLK_PERIOD_NS);
  localparam int unsigned GAP_CYC  = ns_to_cycles(MIN_GAP_NS, CLK_PERIOD_NS);

  logic line_sync;

  bcast_pulse_tx #(
    .HIGH_CYC(HIGH_CYC),
    .GAP_CYC (GAP_CYC)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_req(fire_req),
    .line_out(line_out),
    .busy    (busy)
  );

  bcast_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (line_in),
    .q    (line_sync)
  );

  bcast_edge_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (line_sync),
    .fall_mode(edge_sel),
    .strobe   (act_strobe)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!line_out && !busy && !act_strobe));

endmodule

// File: tb/bcast_trig_top_test.sv
module bcast_trig_top_test;

  localparam int HI = (30 + 9) / 10;
  localparam int GP = (50 + 9) / 10;
  localparam int SPAN = HI + GP;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fire_req = 1'b0;
  logic line_in = 1'b0;
  logic edge_sel = 1'b0;
  logic line_out, busy, act_strobe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bcast_trig_top uut (
    .clk(clk), .rst_n(rst_n), .fire_req(fire_req), .line_out(line_out),
    .busy(busy), .line_in(line_in), .edge_sel(edge_sel), .act_strobe(act_strobe)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    rst_n = 1'b0;
    fire_req = 1'b0;
    line_in = 1'b0;
    edge_sel = sel;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet while held in reset
    check(!line_out && !busy && !act_strobe, "R1 reset",
          {line_out, busy, act_strobe}, 0);
    rst_n = 1'b1;
  endtask

  // A first request at edge 0, then a burst of len requests from edge e.
  task automatic run_tx(input int e, input int len);
    logic [WIN-1:0] lt, bt, el, eb;
    int starts[4];
    int ns, last, prev_end, minlow;
    string tag;
    ns = 1; starts[0] = 0; last = 0;
    for (int r = e; r < e + len; r++) begin
      if (r > last) begin
        last = (r > last + SPAN) ? r : last + SPAN;
        starts[ns] = last;
        ns++;
      end
    end
    el = '0; eb = '0;
    for (int i = 0; i < ns; i++) begin
      for (int s = 0; s < WIN; s++) begin
        if (s - 1 >= starts[i] && s - 1 < starts[i] + HI)   el[s] = 1'b1;
        if (s - 1 >= starts[i] && s - 1 < starts[i] + SPAN) eb[s] = 1'b1;
      end
    end
    do_reset(1'b0);
    for (int n = 0; n < WIN; n++) begin
      @(negedge clk);
      lt[n] = line_out;
      bt[n] = busy;
      fire_req = (n == 0) || (n >= e && n < e + len);
    end
    fire_req = 1'b0;
    if (len > 1)     tag = "R5 merged pulses";
    else if (e < SPAN) tag = "R4 held pulse";
    else              tag = "R2 pulse train";
    check(lt == el, tag, int'(lt), int'(el));
    check(bt == eb, "R6 busy trace", int'(bt), int'(eb));
    // R3: shortest low stretch between two pulses
    prev_end = -1; minlow = 1000;
    for (int s = 1; s < WIN; s++) begin
      if (lt[s] && !lt[s-1] && prev_end >= 0 && (s - prev_end) < minlow)
        minlow = s - prev_end;
      if (!lt[s] && lt[s-1]) prev_end = s;
    end
    check(minlow >= GP, "R3 idle gap", minlow, GP);
  endtask

  // Every 5-bit word driven on the line, one bit per cycle.
  task automatic run_rx(input logic sel);
    localparam int N = 5 * 32;
    logic d [N];
    logic cur, prv, exp;
    do_reset(sel);
    for (int n = 0; n < N + 3; n++) begin
      @(negedge clk);
      cur = (n >= 2 && n - 2 < N) ? d[n-2] : ((n >= 2) ? d[N-1] : 1'b0);
      prv = (n >= 3 && n - 3 < N) ? d[n-3] : ((n >= 3) ? d[N-1] : 1'b0);
      exp = sel ? (prv & ~cur) : (~prv & cur);
      if (sel) check(act_strobe == exp, "R9 falling sweep", act_strobe, exp);
      else     check(act_strobe == exp, "R8 rising sweep", act_strobe, exp);
      if (n < N) begin
        d[n] = ((n / 5) >> (n % 5)) & 1;
        line_in = d[n];
      end
    end
  endtask

  initial begin
    int cnt;
    // R2 R3 R4 R5 R6: request bursts across every offset
    for (int e = 1; e <= SPAN + 6; e++)
      for (int len = 1; len <= 3; len++)
        run_tx(e, len);

    run_rx(1'b0);
    run_rx(1'b1);

    // R7: latency through the synchronizer, rising mode
    do_reset(1'b0);
    @(negedge clk);
    line_in = 1'b1;
    @(negedge clk);
    check(act_strobe == 1'b0, "R7 early strobe", act_strobe, 0);
    @(negedge clk);
    check(act_strobe == 1'b1, "R7 strobe timing", act_strobe, 1);
    // R10: level held long gives one strobe only
    cnt = 0;
    repeat (12) begin
      @(negedge clk);
      if (act_strobe) cnt++;
    end
    check(cnt == 0, "R10 held level", cnt, 0);
    // R8: the falling edge gives no strobe in rising mode
    line_in = 1'b0;
    cnt = 0;
    repeat (6) begin
      @(negedge clk);
      if (act_strobe) cnt++;
    end
    check(cnt == 0, "R8 falling ignored", cnt, 0);

    summary();
    $finish;
  end

endmodule